// File: doc/BRIEF.md
# Multi-Source Reset Sequencer with Cause Flags

This block merges five reset requests into one internal reset for the rest of the chip: power-on, a low external pin, a watchdog timeout, a supply brown-out and a reset bit held by the test access port. The internal reset goes high in the same cycle that any qualified request is present. It is released only after every request has been quiet for a programmable number of cycles, so supplies and clocks can settle before normal operation starts.

The external pin and the brown-out comparator are qualified by run-length filters, so short glitches never reset the chip. A five-bit cause register records which requests have fired. Software reads it and clears bits by writing zeros to them through a small register port. The power-on cause bit survives every reset and is only ever cleared by software. All inputs arrive already synchronised to `clk`. The power-good level also acts as the block's own asynchronous reset.

Top module: `rst_seq_top`

## Requirements
- R1: While `pwr_good` is low, `sys_rst` is high with no clock edge needed, and `cause_rdata` reads 8'h01.
- R2: `sys_rst` is high in every cycle in which any qualified request (filtered pin, filtered brown-out, `wdt_pulse`, `tap_rst`) is high, with no register on that path.
- R3: Once all requests are inactive, `sys_rst` stays high for exactly (`delay_sel`+1)*STEP further cycles (STEP=2 by default), counted from the last active cycle. Any request that reasserts during this window restarts the count from zero.
- R4: `ext_rst_n` low qualifies only from its (EXT_MIN+1)th consecutive low cycle onward (EXT_MIN=3). A low run of EXT_MIN cycles or fewer has no effect on `sys_rst` or on the cause bits.
- R5: A brown-out qualifies only while `bod_en` is 1 and `bod_low` has been 1 for more than BOD_MIN consecutive cycles (BOD_MIN=5). With `bod_en` at 0, `bod_low` has no effect.
- R6: A one-cycle `wdt_pulse` raises `sys_rst` in that cycle, and the hold window starts after its falling edge. `tap_rst` keeps `sys_rst` high for as long as it stays at 1.
- R7: The cause register reads bit 4 test-port, bit 3 watchdog, bit 2 brown-out, bit 1 external pin and bit 0 power-on. Bits 7:5 read 0. A cause bit is set at the clock edge ending any cycle in which its qualified request is active.
- R8: A cycle with `cause_wr` high clears each cause bit whose `cause_wdata` bit is 0. Writing 1 to a bit leaves it unchanged.
- R9: When a cause bit is both set by its request and cleared by a write in the same cycle, the bit ends up set.
- R10: Power-on (`pwr_good` low) clears bits 4:1 and sets bit 0. Bit 0 is cleared only by a software write of 0, never by any other request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| pwr_good | input | 1 | Supply good level; low means power-on reset (asynchronous) |
| ext_rst_n | input | 1 | Synchronised external reset pin, active low |
| wdt_pulse | input | 1 | Watchdog timeout, one cycle wide |
| bod_low | input | 1 | Brown-out comparator output, 1 when supply is low |
| bod_en | input | 1 | Brown-out detection enable |
| tap_rst | input | 1 | Reset bit from the test access port, active high |
| delay_sel | input | 4 | Hold window select, window = (delay_sel+1)*STEP cycles |
| cause_wr | input | 1 | Write strobe for the cause register |
| cause_wdata | input | 5 | Write data; a 0 bit clears the matching cause bit |
| cause_rdata | output | 8 | Cause register read value |
| sys_rst | output | 1 | Internal reset, active high |

## Verification
The bench drives each request alone and then in overlapping combinations. Pin and brown-out low runs of exactly the filter limit, and one cycle longer, tell a correct threshold apart from an off-by-one. Hold windows are measured as whole high-cycle counts for two `delay_sel` values and for back-to-back watchdog pulses, which tells a restarting counter from one that only extends. Writes of all-ones, of all-zeros and of zeros in the same cycle as a request separate the clear-by-zero rule and the set-wins rule from simpler register behaviour. A second power-on then shows which bits it clears.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

  typedef struct packed {
    logic tap;
    logic wdt;
    logic bod;
    logic ext;
    logic por;
  } cause_t;

  localparam int unsigned CAUSE_W = 5;

  // Hold window length in cycles for a given select code.
  function automatic int unsigned hold_cycles(input logic [3:0] sel,
                                              input int unsigned step);
    return (int'(sel) + 1) * step;
  endfunction

  // Next value of the cause register: write-zero clears, request sets, set wins.
  function automatic cause_t cause_next(input cause_t cur, input logic wr,
                                        input cause_t wmask, input cause_t hits);
    cause_t kept;
    kept = wr ? (cur & wmask) : cur;
    return kept | hits;
  endfunction

endpackage

// File: rtl/rst_seq_filter.sv
module rst_seq_filter #(
  parameter int unsigned MIN_RUN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic qual
);
  localparam int unsigned RW = $clog2(MIN_RUN + 1);
  localparam logic [RW-1:0] SAT = RW'(MIN_RUN);

  logic [RW-1:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          run_len <= '0;
    else if (!raw)       run_len <= '0;
    else if (run_len != SAT) run_len <= run_len + 1'b1;
  end

  assign qual = raw && (run_len == SAT);

  // A qualified request needs the raw input in the previous cycle as well.
  assert_filter_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    qual |-> $past(raw));

endmodule

// File: rtl/rst_seq_stretch.sv
module rst_seq_stretch
  import rst_seq_pkg::*;
#(
  parameter int unsigned STEP = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       src_act,
  input  logic [3:0] sel,
  output logic       hold
);
  localparam int unsigned CW = $clog2(16 * STEP + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] last_cnt;
  logic          window_done;

  assign last_cnt    = CW'(hold_cycles(sel, STEP) - 1);
  assign window_done = hold && !src_act && (cnt == last_cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      hold <= 1'b1;
    end else if (src_act) begin
      cnt  <= '0;
      hold <= 1'b1;
    end else if (hold) begin
      if (window_done) hold <= 1'b0;
      else             cnt  <= cnt + 1'b1;
    end
  end

  // Any active request restarts the window from zero.
  assert_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    src_act |=> (hold && cnt == '0));

  // The window never closes while a request is active.
  assert_no_early_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold) |-> !$past(src_act));

endmodule

// File: rtl/rst_seq_flags.sv
module rst_seq_flags
  import rst_seq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  cause_t hits,
  input  logic   wr,
  input  cause_t wmask,
  output cause_t flags
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '{por: 1'b1, default: 1'b0};
    else        flags <= cause_next(flags, wr, wmask, hits);
  end

  // Power-on bit drops only through a software write of zero.
  assert_por_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flags.por) |-> $past(wr && !wmask.por));

  // A request in the same cycle as a clearing write leaves its bit set.
  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|hits) |=> ((flags & $past(hits)) == $past(hits)));

  // Writing a one never changes a bit.
  assert_write_one_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && wmask.ext && !hits.ext) |=> (flags.ext == $past(flags.ext)));

endmodule

// File: rtl/rst_seq_top.sv
module rst_seq_top
  import rst_seq_pkg::*;
#(
  parameter int unsigned EXT_MIN = 3,
  parameter int unsigned BOD_MIN = 5,
  parameter int unsigned STEP    = 2
) (
  input  logic       clk,
  input  logic       pwr_good,
  input  logic       ext_rst_n,
  input  logic       wdt_pulse,
  input  logic       bod_low,
  input  logic       bod_en,
  input  logic       tap_rst,
  input  logic [3:0] delay_sel,
  input  logic       cause_wr,
  input  logic [4:0] cause_wdata,
  output logic [7:0] cause_rdata,
  output logic       sys_rst
);
  logic   ext_q;
  logic   bod_q;
  logic   src_act;
  logic   hold;
  cause_t hits;
  cause_t flags;

  rst_seq_filter #(.MIN_RUN(EXT_MIN)) u_ext_filt (
    .clk(clk), .rst_n(pwr_good), .raw(!ext_rst_n), .qual(ext_q)
  );

  rst_seq_filter #(.MIN_RUN(BOD_MIN)) u_bod_filt (
    .clk(clk), .rst_n(pwr_good), .raw(bod_low && bod_en), .qual(bod_q)
  );

  assign src_act = ext_q || bod_q || wdt_pulse || tap_rst;

  rst_seq_stretch #(.STEP(STEP)) u_stretch (
    .clk(clk), .rst_n(pwr_good), .src_act(src_act), .sel(delay_sel), .hold(hold)
  );

  assign hits = '{tap: tap_rst, wdt: wdt_pulse, bod: bod_q, ext: ext_q, por: 1'b0};

  rst_seq_flags u_flags (
    .clk(clk), .rst_n(pwr_good), .hits(hits), .wr(cause_wr),
    .wmask(cause_t'(cause_wdata)), .flags(flags)
  );

  assign sys_rst     = !pwr_good || src_act || hold;
  assign cause_rdata = {3'b000, flags};

  // Watchdog pulse is recorded in bit 3 at the next edge.
  assert_wdt_flag_R7: assert property (@(posedge clk) disable iff (!pwr_good)
    wdt_pulse |=> cause_rdata[3]);

  // Reset output never drops while the test-port bit is held.
  assert_tap_holds_R6: assert property (@(posedge clk) disable iff (!pwr_good)
    tap_rst |-> sys_rst);

  // Release only after a quiet cycle.
  assert_release_quiet_R3: assert property (@(posedge clk) disable iff (!pwr_good)
    $fell(sys_rst) |-> $past(!src_act));

endmodule

// File: tb/sim_rst_seq_top.sv
`timescale 1ns/1ps
module sim_rst_seq_top;
  localparam int EXT_MIN = 3;
  localparam int BOD_MIN = 5;
  localparam int STEP    = 2;

  logic       clk = 1'b0;
  logic       pwr_good = 1'b0;
  logic       ext_rst_n = 1'b1;
  logic       wdt_pulse = 1'b0;
  logic       bod_low = 1'b0;
  logic       bod_en = 1'b0;
  logic       tap_rst = 1'b0;
  logic [3:0] delay_sel = 4'd2;
  logic       cause_wr = 1'b0;
  logic [4:0] cause_wdata = 5'd0;
  logic [7:0] cause_rdata;
  logic       sys_rst;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  rst_seq_top #(.EXT_MIN(EXT_MIN), .BOD_MIN(BOD_MIN), .STEP(STEP)) u0 (
    .clk(clk), .pwr_good(pwr_good), .ext_rst_n(ext_rst_n), .wdt_pulse(wdt_pulse),
    .bod_low(bod_low), .bod_en(bod_en), .tap_rst(tap_rst), .delay_sel(delay_sel),
    .cause_wr(cause_wr), .cause_wdata(cause_wdata), .cause_rdata(cause_rdata),
    .sys_rst(sys_rst)
  );

  // ---------------- behavioural reference model ----------------
  int   pin_low_streak = 0;
  int   bod_streak     = 0;
  int   cycles_left    = 0;
  logic [4:0] m_cause  = 5'b00001;

  function automatic int window_len(input logic [3:0] s);
    return int'(s) * STEP + STEP;
  endfunction

  function automatic bit pin_ok();
    return !ext_rst_n && pin_low_streak >= EXT_MIN;
  endfunction

  function automatic bit bod_ok();
    return bod_en && bod_low && bod_streak >= BOD_MIN;
  endfunction

  function automatic bit any_req();
    return pin_ok() || bod_ok() || wdt_pulse || tap_rst;
  endfunction

  always @(posedge clk) begin
    if (!pwr_good) begin
      pin_low_streak = 0;
      bod_streak     = 0;
      cycles_left    = window_len(delay_sel);
      m_cause        = 5'b00001;
    end else begin
      bit req;
      logic [4:0] hit;
      req = any_req();
      hit = {tap_rst, wdt_pulse, bod_ok(), pin_ok(), 1'b0};
      if (cause_wr) m_cause = m_cause & cause_wdata;
      m_cause = m_cause | hit;
      if (req) cycles_left = window_len(delay_sel);
      else if (cycles_left > 0) cycles_left = cycles_left - 1;
      pin_low_streak = ext_rst_n ? 0 : (pin_low_streak < 1000 ? pin_low_streak + 1 : 1000);
      bod_streak = (bod_en && bod_low) ? (bod_streak < 1000 ? bod_streak + 1 : 1000) : 0;
    end
  end

  // Per-cycle comparison against the model.
  always @(negedge clk) begin
    if (!done) begin
      bit exp_rst;
      logic [7:0] exp_rd;
      exp_rst = !pwr_good || any_req() || cycles_left > 0;
      exp_rd  = !pwr_good ? 8'h01 : {3'b000, m_cause};
      n_tests++;
      if (sys_rst !== exp_rst) begin
        n_fail++;
        $display("FAIL R2 model sys_rst at %0t: actual %0b expected %0b", $time, sys_rst, exp_rst);
      end
      n_tests++;
      if (cause_rdata !== exp_rd) begin
        n_fail++;
        $display("FAIL R7 model cause at %0t: actual %02h expected %02h", $time, cause_rdata, exp_rd);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic write_cause(input logic [4:0] d);
    @(posedge clk); #1;
    cause_wr = 1'b1; cause_wdata = d;
    @(posedge clk); #1;
    cause_wr = 1'b0;
  endtask

  // Counts consecutive negedges with sys_rst high, starting at the next negedge.
  task automatic count_high(output int n);
    n = 0;
    @(negedge clk);
    while (sys_rst && n < 200) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic wdt_and_measure(output int n);
    @(posedge clk); #1;
    wdt_pulse = 1'b1;
    fork
      begin @(posedge clk); #1; wdt_pulse = 1'b0; end
      count_high(n);
    join
  endtask

  // ---------------- stimulus ----------------
  initial begin
    int n;
    // R1: power-on state
    ticks(3);
    @(negedge clk);
    check("R1 sys_rst during power-on", sys_rst, 1);
    check("R1 cause during power-on", cause_rdata, 8'h01);
    @(posedge clk); #1; pwr_good = 1'b1;
    count_high(n);
    check("R3 hold after power-on, sel=2", n, window_len(4'd2));

    // R8: write ones keeps, write zeros clears power-on bit
    write_cause(5'b11111);
    @(negedge clk); check("R8 write ones keeps cause", cause_rdata, 8'h01);
    write_cause(5'b00000);
    @(negedge clk); check("R8 write zero clears bit 0", cause_rdata, 8'h00);

    // R4: pin low for exactly EXT_MIN cycles is ignored
    @(posedge clk); #1; ext_rst_n = 1'b0;
    ticks(EXT_MIN); ext_rst_n = 1'b1;
    @(negedge clk);
    check("R4 short pin low no reset", sys_rst, 0);
    check("R4 short pin low no cause", cause_rdata, 8'h00);

    // R4/R7: pin low for EXT_MIN+1 cycles resets and sets bit 1
    @(posedge clk); #1; ext_rst_n = 1'b0;
    ticks(EXT_MIN);
    @(negedge clk); check("R2 pin qualifies on 4th low cycle", sys_rst, 1);
    @(posedge clk); #1; ext_rst_n = 1'b1;
    count_high(n);
    check("R3 hold after pin release", n, window_len(4'd2));
    check("R7 external bit 1", cause_rdata, 8'h02);
    write_cause(5'b11101);
    @(negedge clk); check("R8 clear only bit 1", cause_rdata, 8'h00);

    // R5: brown-out ignored while disabled
    @(posedge clk); #1; bod_low = 1'b1; bod_en = 1'b0;
    ticks(12);
    @(negedge clk);
    check("R5 disabled brown-out no reset", sys_rst, 0);
    check("R5 disabled brown-out no cause", cause_rdata, 8'h00);
    bod_low = 1'b0; bod_en = 1'b1;
    // exactly BOD_MIN low cycles: ignored
    @(posedge clk); #1; bod_low = 1'b1;
    ticks(BOD_MIN); bod_low = 1'b0;
    @(negedge clk); check("R5 short brown-out ignored", sys_rst, 0);
    // long brown-out
    @(posedge clk); #1; bod_low = 1'b1;
    ticks(BOD_MIN + 3); bod_low = 1'b0;
    count_high(n);
    check("R5 brown-out hold", n, window_len(4'd2));
    check("R7 brown-out bit 2", cause_rdata, 8'h04);
    write_cause(5'b00000);

    // R6: watchdog pulse: pulse cycle plus window
    wdt_and_measure(n);
    check("R6 watchdog high cycles", n, 1 + window_len(4'd2));
    check("R7 watchdog bit 3", cause_rdata, 8'h08);

    // R3: restart on second pulse three cycles after the first
    @(posedge clk); #1; wdt_pulse = 1'b1;
    fork
      begin
        @(posedge clk); #1; wdt_pulse = 1'b0;
        ticks(2); wdt_pulse = 1'b1;
        @(posedge clk); #1; wdt_pulse = 1'b0;
      end
      count_high(n);
    join
    check("R3 restart on reassert", n, 4 + window_len(4'd2));

    // R6: test-port bit holds reset
    @(posedge clk); #1; tap_rst = 1'b1;
    ticks(4);
    @(negedge clk); check("R6 tap holds reset", sys_rst, 1);
    @(posedge clk); #1; tap_rst = 1'b0;
    count_high(n);
    check("R6 tap release window", n, window_len(4'd2));
    check("R7 tap bit 4", cause_rdata, 8'h18);

    // R9: clearing write in the same cycle as a watchdog pulse
    @(posedge clk); #1; cause_wr = 1'b1; cause_wdata = 5'b00000; wdt_pulse = 1'b1;
    @(posedge clk); #1; cause_wr = 1'b0; wdt_pulse = 1'b0;
    @(negedge clk); check("R9 set wins over clear", cause_rdata, 8'h08);
    ticks(10);

    // R3: another select value
    delay_sel = 4'd0;
    ticks(2);
    wdt_and_measure(n);
    check("R3 window with sel=0", n, 1 + window_len(4'd0));
    delay_sel = 4'd5;
    ticks(2);
    wdt_and_measure(n);
    check("R3 window with sel=5", n, 1 + window_len(4'd5));

    // R10: set all bits then power-on
    @(posedge clk); #1; tap_rst = 1'b1; ext_rst_n = 1'b0;
    ticks(EXT_MIN + 2); tap_rst = 1'b0; ext_rst_n = 1'b1;
    ticks(20);
    @(negedge clk); check("R10 causes before power-on", cause_rdata, 8'h1A);
    @(posedge clk); #1; pwr_good = 1'b0;
    #0.5; check("R1 async reset without edge", sys_rst, 1);
    ticks(2); pwr_good = 1'b1;
    @(negedge clk); check("R10 power-on clears 4:1, sets 0", cause_rdata, 8'h01);
    ticks(20);
    @(negedge clk); check("R10 bit 0 stays without write", cause_rdata, 8'h01);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    n_fail++;
    n_tests++;
    done = 1'b1;
    $display("FAIL watchdog expired R1: actual hung expected finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule